// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The router gathers up to 64 level-sensitive device interrupt lines into one shared raw request register and gives each of four processors its own 64-bit enable mask over that register. Each processor gets a single hard-interrupt output. That output is high whenever at least one raw request bit is set that the processor's mask also enables. A separate legacy-controller interrupt input is merged onto one fixed raw bit, so the cascaded legacy controller appears as an ordinary device line.

Software reaches the block through a simple 64-bit CSR request/response port. Each processor's mask can be read and written. Each processor's masked request view and the shared raw register can only be read. The masked view is not stored: it is formed from the current mask and raw value when the read is served. Only full 8-byte accesses to decoded offsets are accepted. Every other access gets an error response and changes no state.

Top module: `cpu_irq_router`

## Requirements
- R1: The raw request register samples the device lines on every clock. Bit n equals the level of `dev_lines[n]` one cycle after the line settles, so it sets while the line is high and clears while it is low.
- R2: Raw bit 55 is the OR of `dev_lines[55]` and `legacy_irq`, with the same one-cycle sampling as R1.
- R3: `cpu_irq[i]` is registered. One cycle after the registers hold a given mask and raw value, it is 1 exactly when mask i AND raw is non-zero. Line changes and mask writes reach all four outputs by this same path.
- R4: Mask registers live at offsets 0x200 (CPU0), 0x240 (CPU1), 0x600 (CPU2) and 0x640 (CPU3). A valid write stores all 64 bits, and a read returns the stored value.
- R5: A read of offset 0x280, 0x2C0, 0x680 or 0x6C0 returns the mask of CPU0, CPU1, CPU2 or CPU3 (in that order) ANDed with the raw register.
- R6: A read of offset 0x300 returns the raw request register.
- R7: Writes to the masked-request and raw offsets get an OK response and change no mask and no output.
- R8: An access whose `csr_size` is not 8 gets an error response with read data zero. If it is a write, it changes no register.
- R9: An access to an offset that is not decoded gets an error response with read data zero and changes no register. Unaligned offsets count as undecoded.
- R10: While `rst` is high, all masks and the raw register are zero, all `cpu_irq` are low, and no response is signalled.
- R11: Every request gets exactly one response in the following cycle. Read data is zero for writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_lines | input | 64 | Level-sensitive device interrupt lines |
| legacy_irq | input | 1 | Legacy controller interrupt, merged onto raw bit 55 |
| csr_valid | input | 1 | CSR request strobe, one cycle per access |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte offset of the access |
| csr_size | input | 4 | Access size in bytes |
| csr_wdata | input | 64 | Write data |
| csr_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| csr_rsp_err | output | 1 | Error response |
| csr_rdata | output | 64 | Read data |
| cpu_irq | output | 4 | Hard-interrupt output per processor |

## Verification
The bench goes after the non-contiguous offset pattern. A decoder that folded the upper-half masks onto the lower pair would report CPU2 and CPU3 reads with CPU0 and CPU1 contents, and would raise the wrong outputs. It drives a mask write and a line change in the same cycle. A design that stored the masked view, or re-evaluated only the written processor, would leave stale request reads or stale outputs there. Wrong-size accesses, unaligned and unused offsets, and writes to read-only offsets are each followed by mask readback and output observation, so a design that let any of them through would show a changed mask or interrupt. The legacy input is exercised together with, and apart from, device line 55, which catches a design that lost the OR.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int LINE_W     = 64;
    localparam int NUM_CPU    = 4;
    localparam int CPU_IDX_W  = $clog2(NUM_CPU);
    localparam int OFF_W      = 12;
    localparam int SIZE_W     = 4;
    localparam int WORD_BYTES = 8;
    localparam int LEGACY_POS = 55;

    // Offset layout: masks at base + {upper, lower} stride, requests +0x80
    localparam logic [OFF_W-1:0] MASK_BASE    = 12'h200;
    localparam logic [OFF_W-1:0] PEND_DELTA   = 12'h080;
    localparam logic [OFF_W-1:0] LOW_STRIDE   = 12'h040;
    localparam logic [OFF_W-1:0] HIGH_STRIDE  = 12'h400;
    localparam logic [OFF_W-1:0] RAW_OFFSET   = 12'h300;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_PEND,
        SEL_RAW
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e              kind;
        logic [CPU_IDX_W-1:0]   cpu;
    } csr_sel_t;

    typedef struct packed {
        logic                   valid;
        logic                   err;
        logic [LINE_W-1:0]      data;
    } csr_rsp_t;

    function automatic logic [OFF_W-1:0] cpu_offset(input logic [CPU_IDX_W-1:0] c);
        logic [OFF_W-1:0] o;
        o = MASK_BASE;
        if (c[0]) o = o + LOW_STRIDE;
        if (c[1]) o = o + HIGH_STRIDE;
        return o;
    endfunction

    function automatic csr_sel_t decode_offset(input logic [OFF_W-1:0] off);
        csr_sel_t s;
        s.kind = SEL_NONE;
        s.cpu  = '0;
        if (off == RAW_OFFSET) begin
            s.kind = SEL_RAW;
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            if (off == cpu_offset(CPU_IDX_W'(c))) begin
                s.kind = SEL_MASK;
                s.cpu  = CPU_IDX_W'(c);
            end
            if (off == cpu_offset(CPU_IDX_W'(c)) + PEND_DELTA) begin
                s.kind = SEL_PEND;
                s.cpu  = CPU_IDX_W'(c);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture
    import irq_router_pkg::*;
#(
    parameter int WIDTH   = LINE_W,
    parameter int MERGE_AT = LEGACY_POS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lines,
    input  logic             legacy,
    output logic [WIDTH-1:0] raw_q
);
    logic [WIDTH-1:0] merged;

    always_comb begin
        merged = lines;
        merged[MERGE_AT] = lines[MERGE_AT] | legacy;
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= merged;
    end
endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import irq_router_pkg::*;
#(
    parameter int AW = OFF_W,
    parameter int SW = SIZE_W,
    parameter int NC = NUM_CPU
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    output csr_sel_t      sel,
    output logic          err,
    output logic [NC-1:0] mask_we,
    output logic          rd_ok
);
    csr_sel_t dec;

    always_comb begin
        dec  = decode_offset(addr);
        sel  = dec;
        err  = valid && ((size != SW'(WORD_BYTES)) || (dec.kind == SEL_NONE));
        rd_ok = valid && !write && !err;
        mask_we = '0;
        if (valid && write && !err && dec.kind == SEL_MASK)
            mask_we[dec.cpu] = 1'b1;
    end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
    import irq_router_pkg::*;
#(
    parameter int WIDTH = LINE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] pend,
    output logic             irq_q
);
    assign pend = mask_q & raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (we) mask_q <= wdata;
            irq_q <= |pend;
        end
    end
endmodule

// File: rtl/cpu_irq_router.sv
module cpu_irq_router
    import irq_router_pkg::*;
#(
    parameter int DATA_W     = LINE_W,
    parameter int ADDR_W     = OFF_W,
    parameter int SZ_W       = SIZE_W,
    parameter int LEGACY_BIT = LEGACY_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] dev_lines,
    input  logic              legacy_irq,
    input  logic              csr_valid,
    input  logic              csr_write,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [SZ_W-1:0]   csr_size,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic              csr_rsp_valid,
    output logic              csr_rsp_err,
    output logic [DATA_W-1:0] csr_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int NC = NUM_CPU;

    logic [DATA_W-1:0]    raw_q;
    logic [NC*DATA_W-1:0] mask_flat;
    logic [NC*DATA_W-1:0] pend_flat;
    logic [NC-1:0]        mask_we;
    csr_sel_t             sel;
    logic                 acc_err;
    logic                 rd_ok;
    logic [DATA_W-1:0]    rd_mux;
    csr_rsp_t             rsp_q;

    irq_raw_capture #(.WIDTH(DATA_W), .MERGE_AT(LEGACY_BIT)) u_raw (
        .clk    (clk),
        .rst    (rst),
        .lines  (dev_lines),
        .legacy (legacy_irq),
        .raw_q  (raw_q)
    );

    irq_csr_decode #(.AW(ADDR_W), .SW(SZ_W), .NC(NC)) u_dec (
        .valid   (csr_valid),
        .write   (csr_write),
        .addr    (csr_addr),
        .size    (csr_size),
        .sel     (sel),
        .err     (acc_err),
        .mask_we (mask_we),
        .rd_ok   (rd_ok)
    );

    for (genvar g = 0; g < NC; g++) begin : g_cpu
        irq_cpu_slice #(.WIDTH(DATA_W)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .we     (mask_we[g]),
            .wdata  (csr_wdata),
            .raw    (raw_q),
            .mask_q (mask_flat[g*DATA_W +: DATA_W]),
            .pend   (pend_flat[g*DATA_W +: DATA_W]),
            .irq_q  (cpu_irq[g])
        );
    end

    always_comb begin
        unique case (sel.kind)
            SEL_MASK: rd_mux = mask_flat[sel.cpu*DATA_W +: DATA_W];
            SEL_PEND: rd_mux = pend_flat[sel.cpu*DATA_W +: DATA_W];
            SEL_RAW:  rd_mux = raw_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= csr_valid;
            rsp_q.err   <= acc_err;
            rsp_q.data  <= rd_ok ? rd_mux : '0;
        end
    end

    assign csr_rsp_valid = rsp_q.valid;
    assign csr_rsp_err   = rsp_q.err;
    assign csr_rdata     = rsp_q.data;
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
    import irq_router_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [LINE_W-1:0]       dev_lines,
    input logic                    legacy_irq,
    input logic                    csr_valid,
    input logic                    csr_write,
    input logic [OFF_W-1:0]        csr_addr,
    input logic [SIZE_W-1:0]       csr_size,
    input logic                    csr_rsp_valid,
    input logic                    csr_rsp_err,
    input logic [LINE_W-1:0]       csr_rdata,
    input logic [NUM_CPU-1:0]      cpu_irq,
    input logic [LINE_W-1:0]       raw_q,
    input logic [NUM_CPU*LINE_W-1:0] mask_flat
);
    assert_raw_follow_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> raw_q[LEGACY_POS-1:0] == $past(dev_lines[LEGACY_POS-1:0]));

    assert_legacy_merge_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(legacy_irq)) |-> raw_q[LEGACY_POS]);

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_irq
        assert_irq_level_R3: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |->
            cpu_irq[g] == ($past(mask_flat[g*LINE_W +: LINE_W] & raw_q) != '0));
    end

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(csr_valid && csr_write)) |-> $stable(mask_flat));

    assert_ro_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(csr_valid && csr_write && csr_addr == RAW_OFFSET))
        |-> $stable(mask_flat));

    assert_size_err_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(csr_valid && csr_size != SIZE_W'(WORD_BYTES)))
        |-> csr_rsp_err);

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
        csr_rsp_err |-> (csr_rdata == '0 && csr_rsp_valid));

    assert_one_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> csr_rsp_valid == $past(csr_valid));
endmodule

bind cpu_irq_router irq_router_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .dev_lines     (dev_lines),
    .legacy_irq    (legacy_irq),
    .csr_valid     (csr_valid),
    .csr_write     (csr_write),
    .csr_addr      (csr_addr),
    .csr_size      (csr_size),
    .csr_rsp_valid (csr_rsp_valid),
    .csr_rsp_err   (csr_rsp_err),
    .csr_rdata     (csr_rdata),
    .cpu_irq       (cpu_irq),
    .raw_q         (raw_q),
    .mask_flat     (mask_flat)
);

// File: tb/sim_cpu_irq_router.sv
`timescale 1ns/1ps
module sim_cpu_irq_router;
    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] dev_lines = '0;
    logic        legacy_irq = 0;
    logic        csr_valid = 0;
    logic        csr_write = 0;
    logic [11:0] csr_addr = '0;
    logic [3:0]  csr_size = 4'd8;
    logic [63:0] csr_wdata = '0;
    logic        csr_rsp_valid;
    logic        csr_rsp_err;
    logic [63:0] csr_rdata;
    logic [3:0]  cpu_irq;

    always #2 clk = ~clk;   // 250 MHz

    cpu_irq_router u0 (
        .clk(clk), .rst(rst), .dev_lines(dev_lines), .legacy_irq(legacy_irq),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_size(csr_size), .csr_wdata(csr_wdata),
        .csr_rsp_valid(csr_rsp_valid), .csr_rsp_err(csr_rsp_err),
        .csr_rdata(csr_rdata), .cpu_irq(cpu_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference model
    logic [63:0] m_raw;
    logic [63:0] m_mask [4];
    logic [3:0]  m_irq;
    logic        m_rv, m_err;
    logic [63:0] m_rd;
    string       m_tag;
    int          mask_off [4] = '{'h200, 'h240, 'h600, 'h640};
    int          pend_off [4] = '{'h280, 'h2c0, 'h680, 'h6c0};

    always @(posedge clk) begin
        if (rst) begin
            m_raw = '0; m_irq = '0; m_rv = 0; m_err = 0; m_rd = '0;
            for (int i = 0; i < 4; i++) m_mask[i] = '0;
            m_tag = "R10 reset";
        end else begin
            int kind; int cpu;
            for (int i = 0; i < 4; i++) m_irq[i] = |(m_mask[i] & m_raw);  // R3
            m_rv = csr_valid; m_err = 0; m_rd = '0; m_tag = "R3 R11";
            if (csr_valid) begin
                kind = 0; cpu = 0;
                for (int i = 0; i < 4; i++) begin
                    if (int'(csr_addr) == mask_off[i]) begin kind = 1; cpu = i; end
                    if (int'(csr_addr) == pend_off[i]) begin kind = 2; cpu = i; end
                end
                if (csr_addr == 12'h300) kind = 3;
                if (csr_size != 4'd8) begin
                    m_err = 1; m_tag = "R8 size";
                end else if (kind == 0) begin
                    m_err = 1; m_tag = "R9 undecoded";
                end else if (csr_write) begin
                    if (kind == 1) begin m_mask[cpu] = csr_wdata; m_tag = "R4 mask write"; end
                    else m_tag = "R7 read-only write";
                end else begin
                    case (kind)
                        1: begin m_rd = m_mask[cpu]; m_tag = "R4 mask read"; end
                        2: begin m_rd = m_mask[cpu] & m_raw; m_tag = "R5 request read"; end
                        default: begin m_rd = m_raw; m_tag = "R1 R2 R6 raw read"; end
                    endcase
                end
            end
            m_raw = dev_lines;
            m_raw[55] = dev_lines[55] | legacy_irq;   // R1 R2
        end
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            checks++;
            if (cpu_irq !== m_irq || csr_rsp_valid !== m_rv ||
                csr_rsp_err !== m_err || csr_rdata !== m_rd) begin
                fails++;
                $display("FAIL %s: irq=%b rv=%b err=%b rd=%h expected irq=%b rv=%b err=%b rd=%h",
                         m_tag, cpu_irq, csr_rsp_valid, csr_rsp_err, csr_rdata,
                         m_irq, m_rv, m_err, m_rd);
            end
        end
    end

    task automatic access(input bit wr, input logic [11:0] a,
                          input logic [63:0] d, input logic [3:0] sz = 4'd8);
        @(negedge clk);
        csr_valid = 1; csr_write = wr; csr_addr = a; csr_wdata = d; csr_size = sz;
        @(negedge clk);
        csr_valid = 0; csr_write = 0; csr_size = 4'd8;
    endtask

    task automatic lines(input logic [63:0] v, input bit leg = 0);
        @(negedge clk);
        dev_lines = v; legacy_irq = leg;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_all;
        for (int i = 0; i < 4; i++) access(0, 12'(mask_off[i]), '0);
        for (int i = 0; i < 4; i++) access(0, 12'(pend_off[i]), '0);
        access(0, 12'h300, '0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);                          // R10 checked each reset cycle
        @(negedge clk) rst = 0;
        idle(2);
        read_all;                         // all zero after reset (R10)
        // R4: distinct masks, upper pair catches a folded decoder
        access(1, 12'h200, 64'h0000_0000_0000_00ff);
        access(1, 12'h240, 64'h0000_0000_0000_ff00);
        access(1, 12'h600, 64'h00ff_0000_0000_0000);
        access(1, 12'h640, 64'h8000_0000_0001_0000);
        read_all;
        // R1 R3: walking lines
        lines(64'h1);            idle(2); read_all;
        lines(64'h100);          idle(2);
        lines(64'h0001_0000);    idle(2);
        lines(64'h8000_0000_0000_0000); idle(2); read_all;
        lines(64'h0);            idle(2);
        // R2: legacy alone, device line 55 alone, both
        lines(64'h0, 1);         idle(2); read_all;
        lines(64'h0080_0000_0000_0000, 0); idle(2); access(0, 12'h300, '0);
        lines(64'h0080_0000_0000_0000, 1); idle(2); access(0, 12'h6c0, '0);
        lines(64'h0, 0);         idle(2);
        // R3: mask write and line change in the same cycle
        @(negedge clk);
        csr_valid = 1; csr_write = 1; csr_addr = 12'h240; csr_wdata = 64'h4;
        dev_lines = 64'h4;
        @(negedge clk);
        csr_valid = 0; csr_write = 0;
        idle(2); read_all;
        // R7: writes to read-only offsets
        access(1, 12'h280, 64'hffff_ffff_ffff_ffff);
        access(1, 12'h6c0, 64'hffff_ffff_ffff_ffff);
        access(1, 12'h300, 64'hffff_ffff_ffff_ffff);
        read_all;
        // R8: wrong sizes, writes must not land
        access(1, 12'h200, 64'hffff_ffff_ffff_ffff, 4'd4);
        access(0, 12'h300, '0, 4'd1);
        access(1, 12'h640, '0, 4'd0);
        read_all;
        // R9: undecoded and unaligned offsets
        access(1, 12'h000, 64'hffff_ffff_ffff_ffff);
        access(1, 12'h208, 64'hffff_ffff_ffff_ffff);
        access(0, 12'h700, '0);
        access(1, 12'h2a0, 64'hffff_ffff_ffff_ffff);
        read_all;
        // R3: clearing masks drops outputs
        lines(64'hffff_ffff_ffff_ffff, 1); idle(2);
        for (int i = 0; i < 4; i++) access(1, 12'(mask_off[i]), '0);
        idle(2); read_all;
        // back-to-back accesses (R11)
        @(negedge clk);
        csr_valid = 1; csr_write = 1; csr_addr = 12'h600; csr_wdata = 64'h3;
        @(negedge clk);
        csr_write = 0; csr_addr = 12'h680;
        @(negedge clk);
        csr_addr = 12'h300;
        @(negedge clk);
        csr_valid = 0;
        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule